// File: doc/BRIEF.md
# Three-Axis Sample Buffer with Rate-Change Flush

This block stores three-axis acceleration samples (12 bits per axis) in a 32-deep first-in first-out buffer between a sampling front end and a host that reads in bursts. A front end writes one sample on each `smp_valid_i` strobe. The host reads the oldest sample from `pop_data_o` and advances past it with `pop_i`. A fill level, a sticky watermark flag and a sticky overflow flag let the host sleep until enough data has gathered. A counter of refused samples lets the host see whether any data was lost.

Two buffering policies are supported. In fill mode, collection stops at the thirty-second sample so that no data is overwritten. In circular mode the newest sample replaces the oldest, so the buffer always holds the history leading up to an event. A flush removes one entry per clock until the buffer is empty. The host can request a flush, and the block starts one by itself when the sampling domain changes, meaning a new rate code or a sleep/wake transition, because a mix of samples taken at two rates is of no use to the host. Setting a gate input suppresses these automatic flushes. With the gate set, entry into sleep freezes the contents until the host flushes them.

Top module: `accel_sample_fifo`

## Requirements
- R1: After reset the fill count is 0, `empty_o` is 1, the watermark, overflow, flushing and holding outputs are 0, and the refused-sample counter is 0.
- R2: Samples leave in the order they were accepted. A sample is packed with X in bits 11:0, Y in bits 23:12 and Z in bits 35:24, and `pop_data_o` shows the oldest stored sample whenever `empty_o` is 0.
- R3: In fill mode (`circ_mode_i` = 0), the overflow flag rises at the clock edge that stores the 32nd sample. From then on every sample is refused, even after pops free space, until a flush completes. Each refused sample increments the refused-sample counter.
- R4: In circular mode (`circ_mode_i` = 1), a sample arriving while the buffer is full replaces the oldest one. The count stays at 32 and the buffer holds the most recent 32 samples. The overflow flag also rises when the count first reaches 32.
- R5: With a nonzero `wm_level_i`, the watermark flag rises at the edge where the fill count reaches that level and stays set until a flush completes. A level of 0 never raises it.
- R6: A flush removes one entry per clock. It completes in the cycle the buffer is empty. At completion the count is 0 and the overflow flag, the watermark flag and the refused-sample counter are cleared.
- R7: While a flush is in progress (`flushing_o` = 1), arriving samples are discarded without being counted, and `pop_i` has no effect.
- R8: With `hold_gate_i` = 0, a change of `rate_sel_i` or of `sleep_i` starts a flush one clock later.
- R9: With `hold_gate_i` = 1, rate or sleep changes start no flush. A rising `sleep_i` enters a hold state in which pops still work but new samples are refused and counted. After a host flush completes, collection resumes.
- R10: A sample accepted and a pop taken in the same cycle leave the count unchanged.
- R11: The refused-sample counter saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| circ_mode_i | input | 1 | 0: fill mode, 1: circular mode |
| wm_level_i | input | 6 | Watermark level, 0 disables |
| hold_gate_i | input | 1 | Suppress automatic flushes; hold contents on sleep entry |
| sleep_i | input | 1 | System is in the sleep sampling domain |
| rate_sel_i | input | 3 | Active sample-rate code |
| flush_req_i | input | 1 | Host flush request |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 36 | Packed sample {Z, Y, X} |
| pop_i | input | 1 | Host read advance |
| pop_data_o | output | 36 | Oldest stored sample |
| empty_o | output | 1 | Buffer empty |
| count_o | output | 6 | Fill count, 0 to 32 |
| wm_flag_o | output | 1 | Sticky watermark flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| drop_cnt_o | output | 8 | Saturating refused-sample counter |
| flushing_o | output | 1 | Flush in progress |
| holding_o | output | 1 | Contents frozen after gated sleep entry |

## Verification
The embedded properties check on every cycle that the count stays bounded and that it never grows during a drain. They also check that the count never grows in a locked fill-mode buffer, that a simultaneous push and pop leaves the count alone, and that the counter sticks at its ceiling. Two further properties check flag clearing at flush completion and the suppression of automatic flushes by the gate. Only the directed scenarios can show data ordering, which samples survive circular overwrite, the exact edge at which each flag rises, the one-entry-per-clock drain rate, and that hold releases into normal collection after a host flush.

// File: rtl/accel_fifo_pkg.sv
package accel_fifo_pkg;
  localparam int AXIS_W = 12;
  localparam int N_AXES = 3;
  localparam int SMP_W  = AXIS_W * N_AXES;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DRAIN = 2'd2
  } fifo_state_e;
endpackage

// File: rtl/accel_fifo_store.sv
module accel_fifo_store #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                             clk_i,
  input  logic                             we_i,
  input  logic [AW-1:0]                    waddr_i,
  input  logic [accel_fifo_pkg::SMP_W-1:0] wdata_i,
  input  logic [AW-1:0]                    raddr_i,
  output logic [accel_fifo_pkg::SMP_W-1:0] rdata_o
);
  import accel_fifo_pkg::*;

  // one bank per axis
  for (genvar ax = 0; ax < N_AXES; ax++) begin : g_axis
    logic [AXIS_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i[ax*AXIS_W +: AXIS_W];
    end

    assign rdata_o[ax*AXIS_W +: AXIS_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/accel_fifo_mode.sv
module accel_fifo_mode #(
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_req_i,
  input  logic              hold_gate_i,
  input  logic              sleep_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              empty_i,
  output logic              run_o,
  output logic              holding_o,
  output logic              draining_o,
  output logic              done_o
);
  import accel_fifo_pkg::*;

  fifo_state_e       state_q, state_d;
  logic [RATE_W-1:0] rate_q;
  logic              sleep_q;
  logic              dom_change, sleep_rise, start;

  assign dom_change = (rate_sel_i != rate_q) || (sleep_i != sleep_q);
  assign sleep_rise = sleep_i && !sleep_q;
  assign start      = flush_req_i || (dom_change && !hold_gate_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (start)                          state_d = ST_DRAIN;
        else if (hold_gate_i && sleep_rise) state_d = ST_HOLD;
      end
      ST_HOLD:  if (start)   state_d = ST_DRAIN;
      ST_DRAIN: if (empty_i) state_d = ST_RUN;
      default:               state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      rate_q  <= '0;
      sleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rate_q  <= rate_sel_i;
      sleep_q <= sleep_i;
    end
  end

  assign run_o      = (state_q == ST_RUN);
  assign holding_o  = (state_q == ST_HOLD);
  assign draining_o = (state_q == ST_DRAIN);
  assign done_o     = draining_o && empty_i;

  assert_host_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DRAIN && flush_req_i) |=> state_q == ST_DRAIN);

  assert_gate_blocks_auto_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_gate_i && !flush_req_i && state_q != ST_DRAIN) |=> state_q != ST_DRAIN);
endmodule

// File: rtl/accel_fifo_ptrs.sv
module accel_fifo_ptrs #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          circ_mode_i,
  input  logic          smp_valid_i,
  input  logic          pop_i,
  input  logic          run_i,
  input  logic          draining_i,
  input  logic          ovf_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_d_o,
  output logic          push_acc_o,
  output logic          drop_evt_o,
  output logic          empty_o
);
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q, count_d;
  logic full, empty, blocked, push_acc, pop_acc, drain_step, dec, ovw;

  assign full       = (count_q == CW'(DEPTH));
  assign empty      = (count_q == '0);
  assign blocked    = !run_i || (!circ_mode_i && (ovf_i || full));
  assign push_acc   = smp_valid_i && !blocked;
  assign pop_acc    = pop_i && !empty && !draining_i;
  assign drain_step = draining_i && !empty;
  assign dec        = pop_acc || drain_step;
  assign ovw        = push_acc && full && !dec;   // circular overwrite of oldest

  always_comb begin
    count_d = count_q;
    if (push_acc && !dec && !full) count_d = count_q + 1'b1;
    else if (!push_acc && dec)     count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_acc)   wr_q <= wr_q + 1'b1;
      if (dec || ovw) rd_q <= rd_q + 1'b1;
      count_q <= count_d;
    end
  end

  assign we_o       = push_acc;
  assign waddr_o    = wr_q;
  assign raddr_o    = rd_q;
  assign count_o    = count_q;
  assign count_d_o  = count_d;
  assign push_acc_o = push_acc;
  assign drop_evt_o = smp_valid_i && blocked && !draining_i;
  assign empty_o    = empty;

  assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  assert_pushpop_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_acc && pop_acc) |=> count_q == $past(count_q));

  assert_drain_no_grow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    draining_i |=> count_q <= $past(count_q));

  assert_fill_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!circ_mode_i && ovf_i) |=> count_q <= $past(count_q));
endmodule

// File: rtl/accel_fifo_status.sv
module accel_fifo_status #(
  parameter int DEPTH  = 32,
  parameter int DROP_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     wm_level_i,
  input  logic [CW-1:0]     count_d_i,
  input  logic              push_acc_i,
  input  logic              drop_evt_i,
  input  logic              done_i,
  output logic              wm_o,
  output logic              ovf_o,
  output logic [DROP_W-1:0] drop_o
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic              wm_q, ovf_q;
  logic [DROP_W-1:0] drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm_q   <= 1'b0;
      ovf_q  <= 1'b0;
      drop_q <= '0;
    end else if (done_i) begin
      wm_q   <= 1'b0;
      ovf_q  <= 1'b0;
      drop_q <= '0;
    end else begin
      if (wm_level_i != '0 && count_d_i >= wm_level_i)  wm_q  <= 1'b1;
      if (push_acc_i && count_d_i == CW'(DEPTH))        ovf_q <= 1'b1;
      if (drop_evt_i && drop_q != DROP_MAX)             drop_q <= drop_q + 1'b1;
    end
  end

  assign wm_o   = wm_q;
  assign ovf_o  = ovf_q;
  assign drop_o = drop_q;

  assert_drop_saturate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_q == DROP_MAX && !done_i) |=> drop_q == DROP_MAX);

  assert_flags_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!ovf_q && !wm_q && drop_q == '0));
endmodule

// File: rtl/accel_sample_fifo.sv
module accel_sample_fifo #(
  parameter int DEPTH  = 32,
  parameter int RATE_W = 3,
  parameter int DROP_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             circ_mode_i,
  input  logic [CW-1:0]                    wm_level_i,
  input  logic                             hold_gate_i,
  input  logic                             sleep_i,
  input  logic [RATE_W-1:0]                rate_sel_i,
  input  logic                             flush_req_i,
  input  logic                             smp_valid_i,
  input  logic [accel_fifo_pkg::SMP_W-1:0] smp_data_i,
  input  logic                             pop_i,
  output logic [accel_fifo_pkg::SMP_W-1:0] pop_data_o,
  output logic                             empty_o,
  output logic [CW-1:0]                    count_o,
  output logic                             wm_flag_o,
  output logic                             ovf_flag_o,
  output logic [DROP_W-1:0]                drop_cnt_o,
  output logic                             flushing_o,
  output logic                             holding_o
);
  logic          run, draining, done, empty, we, push_acc, drop_evt, ovf;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count_d;

  accel_fifo_mode #(.RATE_W(RATE_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_req_i(flush_req_i),
    .hold_gate_i(hold_gate_i),
    .sleep_i    (sleep_i),
    .rate_sel_i (rate_sel_i),
    .empty_i    (empty),
    .run_o      (run),
    .holding_o  (holding_o),
    .draining_o (draining),
    .done_o     (done)
  );

  accel_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .circ_mode_i(circ_mode_i),
    .smp_valid_i(smp_valid_i),
    .pop_i      (pop_i),
    .run_i      (run),
    .draining_i (draining),
    .ovf_i      (ovf),
    .we_o       (we),
    .waddr_o    (waddr),
    .raddr_o    (raddr),
    .count_o    (count_o),
    .count_d_o  (count_d),
    .push_acc_o (push_acc),
    .drop_evt_o (drop_evt),
    .empty_o    (empty)
  );

  accel_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(smp_data_i),
    .raddr_i(raddr),
    .rdata_o(pop_data_o)
  );

  accel_fifo_status #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wm_level_i(wm_level_i),
    .count_d_i (count_d),
    .push_acc_i(push_acc),
    .drop_evt_i(drop_evt),
    .done_i    (done),
    .wm_o      (wm_flag_o),
    .ovf_o     (ovf),
    .drop_o    (drop_cnt_o)
  );

  assign ovf_flag_o = ovf;
  assign empty_o    = empty;
  assign flushing_o = draining;
endmodule

// File: tb/accel_sample_fifo_tb_top.sv
module accel_sample_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        circ_mode = 1'b0;
  logic [5:0]  wm_level = '0;
  logic        hold_gate = 1'b0;
  logic        sleep = 1'b0;
  logic [2:0]  rate_sel = '0;
  logic        flush_req = 1'b0;
  logic        smp_valid = 1'b0;
  logic [35:0] smp_data = '0;
  logic        pop = 1'b0;
  logic [35:0] pop_data;
  logic        empty;
  logic [5:0]  count;
  logic        wm_flag, ovf_flag, flushing, holding;
  logic [7:0]  drop_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  accel_sample_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .circ_mode_i(circ_mode), .wm_level_i(wm_level),
    .hold_gate_i(hold_gate), .sleep_i(sleep), .rate_sel_i(rate_sel),
    .flush_req_i(flush_req), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .pop_i(pop), .pop_data_o(pop_data), .empty_o(empty), .count_o(count),
    .wm_flag_o(wm_flag), .ovf_flag_o(ovf_flag), .drop_cnt_o(drop_cnt),
    .flushing_o(flushing), .holding_o(holding)
  );

  function automatic logic [35:0] smp(input int i);
    return {12'(i * 3 + 1), 12'(i * 5 + 2), 12'(i + 100)};
  endfunction

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic push(input int i);
    smp_valid = 1'b1;
    smp_data  = smp(i);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic push_pop(input int i);
    smp_valid = 1'b1;
    smp_data  = smp(i);
    pop       = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    pop       = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 200 && flushing; k++) @(negedge clk);
  endtask

  task automatic host_flush();
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    wait_drain();
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 empty", empty, 1);
    check("R1 flags", {wm_flag, ovf_flag, flushing, holding}, 0);
    check("R1 drop", drop_cnt, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(i);
    check("R2 count", count, 5);
    for (int i = 0; i < 5; i++) begin
      check("R2 data", pop_data, smp(i));
      do_pop();
    end
    check("R2 empty", empty, 1);
  endtask

  task automatic t_pushpop();
    push(10);
    push(11);
    push_pop(12);
    check("R10 count", count, 2);
    check("R10 head", pop_data, smp(11));
    host_flush();
  endtask

  task automatic t_fill();
    circ_mode = 1'b0;
    wm_level  = 6'd30;
    for (int i = 0; i < 29; i++) push(i);
    check("R5 wm below", wm_flag, 0);
    push(29);
    check("R5 wm at level", wm_flag, 1);
    push(30);
    check("R3 ovf before 32", ovf_flag, 0);
    push(31);
    check("R3 ovf at 32", ovf_flag, 1);
    push(32);
    check("R3 refused count", count, 32);
    check("R3 refused drop", drop_cnt, 1);
    do_pop();
    push(33);
    check("R3 locked after pop", count, 31);
    check("R3 drop after pop", drop_cnt, 2);
    check("R5 wm sticky", wm_flag, 1);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    check("R6 flushing", flushing, 1);
    check("R6 first", count, 31);
    push(34);
    check("R6 one per clock", count, 30);
    check("R7 drain drop uncounted", drop_cnt, 2);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    check("R7 pop ignored", count, 29);
    wait_drain();
    check("R6 count zero", count, 0);
    check("R6 flags cleared", {wm_flag, ovf_flag}, 0);
    check("R6 drop cleared", drop_cnt, 0);
    push(40);
    check("R6 resumes", pop_data, smp(40));
    host_flush();
  endtask

  task automatic t_circ();
    circ_mode = 1'b1;
    wm_level  = 6'd0;
    for (int i = 0; i < 40; i++) push(100 + i);
    check("R4 count", count, 32);
    check("R4 oldest kept", pop_data, smp(108));
    check("R4 ovf", ovf_flag, 1);
    check("R5 level zero", wm_flag, 0);
    check("R4 no drops", drop_cnt, 0);
    rate_sel = 3'd1;
    @(negedge clk);
    check("R8 rate flush", flushing, 1);
    wait_drain();
    check("R8 rate emptied", count, 0);
  endtask

  task automatic t_sleep_auto();
    hold_gate = 1'b0;
    for (int i = 0; i < 3; i++) push(200 + i);
    sleep = 1'b1;
    @(negedge clk);
    check("R8 sleep flush", flushing, 1);
    wait_drain();
    check("R8 sleep emptied", count, 0);
    sleep = 1'b0;
    @(negedge clk);
    wait_drain();
  endtask

  task automatic t_gate();
    hold_gate = 1'b1;
    for (int i = 0; i < 4; i++) push(300 + i);
    rate_sel = 3'd2;
    @(negedge clk);
    check("R9 no rate flush", flushing, 0);
    check("R9 kept", count, 4);
    sleep = 1'b1;
    @(negedge clk);
    check("R9 holding", holding, 1);
    check("R9 no sleep flush", count, 4);
    push(310);
    push(311);
    check("R9 refused", count, 4);
    check("R9 refused counted", drop_cnt, 2);
    check("R9 held data", pop_data, smp(300));
    do_pop();
    check("R9 pop in hold", count, 3);
    host_flush();
    check("R9 released", holding, 0);
    push(320);
    check("R9 collects", count, 1);
    check("R9 data", pop_data, smp(320));
    sleep = 1'b0;
    @(negedge clk);
    host_flush();
    hold_gate = 1'b0;
  endtask

  task automatic t_sat();
    circ_mode = 1'b0;
    for (int i = 0; i < 32; i++) push(i);
    for (int i = 0; i < 300; i++) push(500 + i);
    check("R11 saturate", drop_cnt, 255);
    check("R11 count", count, 32);
    host_flush();
    check("R11 cleared", drop_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_pushpop();
    t_fill();
    t_circ();
    t_sleep_auto();
    t_gate();
    t_sat();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule